// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads descriptors from a two-level page table in memory through a simple read port, and it judges whether the access is allowed. A translation request carries the virtual address, the access kind (read, write or execute) and a user/privileged flag. The table base and the translation-enable bit are sampled when the request is accepted.

A walk ends in one of two ways: a 4 MB superpage found in the first level, or a 4 KB page found in the second level. Two cases skip the walk entirely. With translation off, the address passes through unchanged. A privileged access to the low half of the address space is redirected to the upper half.

Every request ends with one `done` pulse. The pulse carries:
- the physical address;
- a page-size flag;
- three protection bits;
- a fault code, which is zero on success.

On a fault, the code and the virtual address are held in two status registers. An instruction trap or a data trap pulses together with `done`.

Top module: `pgwalk_top`

## Requirements
- R1: With `mmu_on` low, an accepted request completes with `done` one cycle after acceptance. It returns `res_paddr` equal to the virtual address, `res_prot` = 3'b111, `res_super` = 0 and `res_fault` = 0, and issues no memory read.
- R2: With `mmu_on` high, a privileged request (`req_user` = 0) whose address bit 31 is 0 behaves as in R1, except that `res_paddr` is the virtual address with bit 31 set.
- R3: All other requests start a walk. The first read address is {base[31:12], va[31:22], 2'b00}. Only one read is outstanding at a time. `mem_rd_req` and `mem_rd_addr` stay steady until `mem_rd_valid` is seen.
- R4: Descriptor bits [1:0] give the type and bit 2 marks the entry as present. A first-level type-3 entry that is present is a superpage: `res_paddr` = {desc[31:22], va[21:0]} and `res_super` = 1. If that entry is not present, the fault code is 0x0B.
- R5: A first-level type-0 entry that is not present faults with 0x05. If it is present, a second read follows at {desc[31:12], va[21:12], 2'b00}.
- R6: A second-level entry that is not present faults with 0x08. Otherwise `res_paddr` = {desc[31:12], va[11:0]} and `res_super` = 0.
- R7: A first-level type of 1 or 2, or a present second-level entry whose type is not 0, faults with 0x1F.
- R8: On a successful walk, `res_prot` holds the bits of the final descriptor: bit 0 = desc[8] (read), bit 1 = desc[7] (write), bit 2 = desc[6] (execute).
- R9: A user access faults when the final descriptor lacks the needed bit: 0x11 for a read, 0x12 for a write, 0x13 for an execute. The access code is 0 for read, 1 for write, 2 for execute; code 3 is treated as read. Privileged accesses never fault on permissions. When a fault occurs, `res_paddr`, `res_prot` and `res_super` are 0.
- R10: On each fault, `flt_status` takes the code and `flt_addr` takes the virtual address, visible with `done`. Both reset to 0 and are unchanged by successful requests.
- R11: A fault pulses `itrap` for execute accesses and `dtrap` for all other accesses, in the same cycle as `done`. A success pulses neither.
- R12: `done` lasts one cycle per accepted request. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for user access, 0 for privileged |
| tbl_base | input | 32 | Page table base; bits [31:12] used |
| mmu_on | input | 1 | Translation enable |
| mem_rd_req | output | 1 | Descriptor read request, held until valid |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| res_paddr | output | 32 | Physical address |
| res_super | output | 1 | 1 when the mapping is a 4 MB superpage |
| res_prot | output | 3 | {execute, write, read} permissions |
| res_fault | output | 5 | Fault code, 0 on success |
| flt_status | output | 5 | Last fault code |
| flt_addr | output | 32 | Virtual address of the last fault |
| itrap | output | 1 | Instruction trap pulse |
| dtrap | output | 1 | Data trap pulse |

## Verification
Each state error shows at the ports on a specific cycle:
- A wrong descriptor type or wrong present decode appears at the very next `done` pulse, as a different fault code or a different physical address.
- A wrong latched address or latched table base shows even earlier, on `mem_rd_addr` during the first read. The memory model compares that address against its own computation.
- A fault register that is updated when it should not be stays visible on `flt_status` and `flt_addr` at every later `done`, so a single stray write is still caught many requests afterwards.
- A controller that loses or invents a walk produces a `done` with no expected item, or an item that never completes.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int VA_W   = 32;
  localparam int FC_W   = 5;
  localparam int PROT_W = 3;
  localparam int PG_LSB = 12;
  localparam int SP_LSB = 22;

  typedef logic [VA_W-1:0] addr_t;
  typedef logic [FC_W-1:0] fcode_t;
  typedef logic [1:0]      acc_t;

  localparam acc_t ACC_RD = 2'd0;
  localparam acc_t ACC_WR = 2'd1;
  localparam acc_t ACC_EX = 2'd2;

  localparam fcode_t FC_OK       = 5'h00;
  localparam fcode_t FC_L1_MISS  = 5'h05;
  localparam fcode_t FC_PG_MISS  = 5'h08;
  localparam fcode_t FC_SP_MISS  = 5'h0B;
  localparam fcode_t FC_NO_RD    = 5'h11;
  localparam fcode_t FC_NO_WR    = 5'h12;
  localparam fcode_t FC_NO_EX    = 5'h13;
  localparam fcode_t FC_BAD_TYPE = 5'h1F;

  localparam logic [1:0] DT_TABLE = 2'd0;
  localparam logic [1:0] DT_SUPER = 2'd3;
  localparam int PRES_BIT = 2;
  localparam int RD_BIT   = 8;
  localparam int WR_BIT   = 7;
  localparam int EX_BIT   = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} walk_st_e;

  function automatic addr_t l1_addr(addr_t base, addr_t va);
    return {base[VA_W-1:PG_LSB], va[VA_W-1:SP_LSB], 2'b00};
  endfunction

  function automatic addr_t l2_addr(addr_t desc, addr_t va);
    return {desc[VA_W-1:PG_LSB], va[SP_LSB-1:PG_LSB], 2'b00};
  endfunction

  function automatic addr_t super_pa(addr_t desc, addr_t va);
    return {desc[VA_W-1:SP_LSB], va[SP_LSB-1:0]};
  endfunction

  function automatic addr_t page_pa(addr_t desc, addr_t va);
    return {desc[VA_W-1:PG_LSB], va[PG_LSB-1:0]};
  endfunction

  function automatic addr_t io_pa(addr_t va);
    return {1'b1, va[VA_W-2:0]};
  endfunction

  function automatic logic is_io(addr_t va, logic user);
    return !user && !va[VA_W-1];
  endfunction

endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
  import pgwalk_pkg::*;
(
  input  addr_t              desc_i,
  input  acc_t               acc_i,
  input  logic               user_i,
  output logic [PROT_W-1:0]  prot_o,
  output fcode_t             code_o
);

  logic [PROT_W-1:0] need;
  logic [PROT_W-1:0] miss;

  always_comb begin
    case (acc_i)
      ACC_WR:  need = 3'b010;
      ACC_EX:  need = 3'b100;
      default: need = 3'b001;
    endcase
  end

  for (genvar i = 0; i < PROT_W; i++) begin : g_bit
    assign prot_o[i] = desc_i[RD_BIT - i];
    assign miss[i]   = user_i && need[i] && !prot_o[i];
  end

  always_comb begin
    if (miss[0])      code_o = FC_NO_RD;
    else if (miss[1]) code_o = FC_NO_WR;
    else if (miss[2]) code_o = FC_NO_EX;
    else              code_o = FC_OK;
  end

endmodule

// File: rtl/pgwalk_ctl.sv
module pgwalk_ctl
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  addr_t             req_vaddr,
  input  acc_t              req_acc,
  input  logic              req_user,
  input  addr_t             tbl_base,
  input  logic              mmu_on,
  output logic              mem_rd_req,
  output addr_t             mem_rd_addr,
  input  logic              mem_rd_valid,
  input  addr_t             mem_rd_data,
  input  logic [PROT_W-1:0] perm_prot,
  input  fcode_t            perm_code,
  output logic              busy,
  output logic              done,
  output addr_t             res_paddr,
  output logic              res_super,
  output logic [PROT_W-1:0] res_prot,
  output fcode_t            res_fault,
  output logic              fin_ev,
  output fcode_t            fin_code,
  output addr_t             act_va,
  output acc_t              act_acc,
  output logic              walk_user
);

  walk_st_e st_q, st_d;
  addr_t    rd_addr_q, rd_addr_d;
  addr_t    va_q;
  acc_t     acc_q;
  logic     user_q;

  addr_t             fin_pa;
  logic              fin_sup;
  logic [PROT_W-1:0] fin_prot;
  logic              accept;
  logic [1:0]        dtype;
  logic              present;

  assign dtype   = mem_rd_data[1:0];
  assign present = mem_rd_data[PRES_BIT];

  assign act_va    = (st_q == ST_IDLE) ? req_vaddr : va_q;
  assign act_acc   = (st_q == ST_IDLE) ? req_acc   : acc_q;
  assign walk_user = user_q;

  assign busy        = (st_q != ST_IDLE);
  assign mem_rd_req  = busy;
  assign mem_rd_addr = rd_addr_q;

  always_comb begin
    st_d      = st_q;
    rd_addr_d = rd_addr_q;
    accept    = 1'b0;
    fin_ev    = 1'b0;
    fin_code  = FC_OK;
    fin_pa    = '0;
    fin_sup   = 1'b0;
    fin_prot  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (!mmu_on) begin
            fin_ev   = 1'b1;
            fin_pa   = req_vaddr;
            fin_prot = '1;
          end else if (is_io(req_vaddr, req_user)) begin
            fin_ev   = 1'b1;
            fin_pa   = io_pa(req_vaddr);
            fin_prot = '1;
          end else begin
            st_d      = ST_L1;
            rd_addr_d = l1_addr(tbl_base, req_vaddr);
          end
        end
      end
      ST_L1: begin
        if (mem_rd_valid) begin
          if (dtype == DT_SUPER) begin
            fin_ev = 1'b1;
            if (!present) begin
              fin_code = FC_SP_MISS;
            end else begin
              fin_code = perm_code;
              fin_pa   = super_pa(mem_rd_data, va_q);
              fin_sup  = 1'b1;
              fin_prot = perm_prot;
            end
          end else if (dtype == DT_TABLE) begin
            if (!present) begin
              fin_ev   = 1'b1;
              fin_code = FC_L1_MISS;
            end else begin
              st_d      = ST_L2;
              rd_addr_d = l2_addr(mem_rd_data, va_q);
            end
          end else begin
            fin_ev   = 1'b1;
            fin_code = FC_BAD_TYPE;
          end
        end
      end
      ST_L2: begin
        if (mem_rd_valid) begin
          fin_ev = 1'b1;
          if (!present) begin
            fin_code = FC_PG_MISS;
          end else if (dtype != DT_TABLE) begin
            fin_code = FC_BAD_TYPE;
          end else begin
            fin_code = perm_code;
            fin_pa   = page_pa(mem_rd_data, va_q);
            fin_prot = perm_prot;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin_ev) begin
      st_d = ST_IDLE;
      if (fin_code != FC_OK) begin
        fin_pa   = '0;
        fin_sup  = 1'b0;
        fin_prot = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rd_addr_q <= '0;
      va_q      <= '0;
      acc_q     <= ACC_RD;
      user_q    <= 1'b0;
      done      <= 1'b0;
      res_paddr <= '0;
      res_super <= 1'b0;
      res_prot  <= '0;
      res_fault <= FC_OK;
    end else begin
      st_q      <= st_d;
      rd_addr_q <= rd_addr_d;
      done      <= fin_ev;
      if (accept) begin
        va_q   <= req_vaddr;
        acc_q  <= req_acc;
        user_q <= req_user;
      end
      if (fin_ev) begin
        res_paddr <= fin_pa;
        res_super <= fin_sup;
        res_prot  <= fin_prot;
        res_fault <= fin_code;
      end
    end
  end

endmodule

// File: rtl/pgwalk_flt.sv
module pgwalk_flt
  import pgwalk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fin_ev,
  input  fcode_t fin_code,
  input  addr_t  act_va,
  input  acc_t   act_acc,
  output fcode_t flt_status,
  output addr_t  flt_addr,
  output logic   itrap,
  output logic   dtrap
);

  logic is_fault;
  assign is_fault = fin_ev && (fin_code != FC_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_status <= FC_OK;
      flt_addr   <= '0;
      itrap      <= 1'b0;
      dtrap      <= 1'b0;
    end else begin
      itrap <= is_fault && (act_acc == ACC_EX);
      dtrap <= is_fault && (act_acc != ACC_EX);
      if (is_fault) begin
        flt_status <= fin_code;
        flt_addr   <= act_va;
      end
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic        req_user,
  input  logic [31:0] tbl_base,
  input  logic        mmu_on,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        busy,
  output logic        done,
  output logic [31:0] res_paddr,
  output logic        res_super,
  output logic [2:0]  res_prot,
  output logic [4:0]  res_fault,
  output logic [4:0]  flt_status,
  output logic [31:0] flt_addr,
  output logic        itrap,
  output logic        dtrap
);

  logic [PROT_W-1:0] perm_prot;
  fcode_t            perm_code;
  logic              fin_ev;
  fcode_t            fin_code;
  addr_t             act_va;
  acc_t              act_acc;
  logic              walk_user;

  pgwalk_perm u_perm (
    .desc_i (mem_rd_data),
    .acc_i  (act_acc),
    .user_i (walk_user),
    .prot_o (perm_prot),
    .code_o (perm_code)
  );

  pgwalk_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_acc      (req_acc),
    .req_user     (req_user),
    .tbl_base     (tbl_base),
    .mmu_on       (mmu_on),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .perm_prot    (perm_prot),
    .perm_code    (perm_code),
    .busy         (busy),
    .done         (done),
    .res_paddr    (res_paddr),
    .res_super    (res_super),
    .res_prot     (res_prot),
    .res_fault    (res_fault),
    .fin_ev       (fin_ev),
    .fin_code     (fin_code),
    .act_va       (act_va),
    .act_acc      (act_acc),
    .walk_user    (walk_user)
  );

  pgwalk_flt u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin_ev     (fin_ev),
    .fin_code   (fin_code),
    .act_va     (act_va),
    .act_acc    (act_acc),
    .flt_status (flt_status),
    .flt_addr   (flt_addr),
    .itrap      (itrap),
    .dtrap      (dtrap)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_rd_req,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        done,
  input logic        res_super,
  input logic [4:0]  res_fault,
  input logic [4:0]  flt_status,
  input logic [31:0] flt_addr,
  input logic        itrap,
  input logic        dtrap,
  input logic        walk_user
);

  // R3: a pending read keeps its request and address
  a_r3_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R3: reads only happen during a walk
  a_r3_read_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> busy);

  // R4: a superpage result is never a fault
  a_r4_super_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_super) |-> (res_fault == 5'h00));

  // R9: permission fault codes come only from user walks
  a_r9_priv_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res_fault == 5'h11 || res_fault == 5'h12 || res_fault == 5'h13)) |-> walk_user);

  // R10: fault registers move only together with done
  a_r10_flt_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(flt_status) || !$stable(flt_addr)) |-> done);

  // R11: at most one trap, only on a faulting done
  a_r11_trap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({itrap, dtrap}));

  a_r11_trap_done: assert property (@(posedge clk) disable iff (!rst_n)
    (itrap || dtrap) |-> (done && res_fault != 5'h00));

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind pgwalk_top pgwalk_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .done         (done),
  .res_super    (res_super),
  .res_fault    (res_fault),
  .flt_status   (flt_status),
  .flt_addr     (flt_addr),
  .itrap        (itrap),
  .dtrap        (dtrap),
  .walk_user    (walk_user)
);

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        mmu_on = 1'b0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        busy, done, res_super, itrap, dtrap;
  logic [31:0] res_paddr, flt_addr;
  logic [2:0]  res_prot;
  logic [4:0]  res_fault, flt_status;

  always #2 clk = ~clk;

  pgwalk_top u0 (.*);

  typedef struct {
    string       tag;
    logic [31:0] pa;
    logic        sup;
    logic [2:0]  prot;
    logic [4:0]  code;
    logic        it;
    logic        dt;
    logic [4:0]  fs;
    logic [31:0] fa;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] rd_q[$];
  logic [31:0] tbl [logic [31:0]];
  int          checks = 0;
  int          errors = 0;
  int          lat = 0;
  logic [4:0]  m_fs = '0;
  logic [31:0] m_fa = '0;
  bit          finished = 0;

  localparam logic [31:0] BASE = 32'h0010_0000;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rdm(logic [31:0] a);
    return tbl.exists(a) ? tbl[a] : 32'h0;
  endfunction

  function automatic exp_t model(string tag, logic [31:0] va, logic [1:0] acc,
                                 logic user, logic mmu);
    exp_t e;
    logic [31:0] a1, a2, d1, d2, d;
    logic ok;
    logic r, w, x;
    e.tag = tag; e.pa = 0; e.sup = 0; e.prot = 0; e.code = 0; e.it = 0; e.dt = 0;
    ok = 0; d = 0;
    if (!mmu) begin
      e.pa = va; e.prot = 3'b111;
    end else if (!user && va < 32'h8000_0000) begin
      e.pa = va + 32'h8000_0000; e.prot = 3'b111;
    end else begin
      a1 = (BASE & 32'hFFFF_F000) + ((va >> 22) << 2);
      rd_q.push_back(a1);
      d1 = rdm(a1);
      if (d1 % 4 == 3) begin
        if (((d1 >> 2) & 1) == 0) e.code = 5'h0B;
        else begin
          e.pa = (d1 & 32'hFFC0_0000) + (va & 32'h003F_FFFF);
          e.sup = 1; d = d1; ok = 1;
        end
      end else if (d1 % 4 == 0) begin
        if (((d1 >> 2) & 1) == 0) e.code = 5'h05;
        else begin
          a2 = (d1 & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 4);
          rd_q.push_back(a2);
          d2 = rdm(a2);
          if (((d2 >> 2) & 1) == 0) e.code = 5'h08;
          else if (d2 % 4 != 0) e.code = 5'h1F;
          else begin
            e.pa = (d2 & 32'hFFFF_F000) + (va & 32'hFFF); d = d2; ok = 1;
          end
        end
      end else e.code = 5'h1F;
      if (ok) begin
        r = d[8]; w = d[7]; x = d[6];
        e.prot = {x, w, r};
        if (user) begin
          if (acc == 2'd1 && !w) e.code = 5'h12;
          else if (acc == 2'd2 && !x) e.code = 5'h13;
          else if (acc != 2'd1 && acc != 2'd2 && !r) e.code = 5'h11;
        end
      end
    end
    if (e.code != 0) begin
      e.pa = 0; e.prot = 0; e.sup = 0;
      e.it = (acc == 2'd2); e.dt = (acc != 2'd2);
      m_fs = e.code; m_fa = va;
    end
    e.fs = m_fs; e.fa = m_fa;
    return e;
  endfunction

  task automatic run(string tag, logic [31:0] va, logic [1:0] acc, logic user,
                     logic mmu, bit poke = 0);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    mmu_on = mmu; tbl_base = BASE;
    e = model(tag, va, acc, user, mmu);
    exp_q.push_back(e);
    req_valid = 1; req_vaddr = va; req_acc = acc; req_user = user;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      // R12: a request raised while busy must be dropped
      @(negedge clk);
      req_valid = 1; req_vaddr = 32'h0000_1000; req_acc = 0; req_user = 0;
      @(negedge clk);
      req_valid = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // memory model: one read at a time, latency lat cycles
  initial begin
    bit pend = 0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 0;
      if (mem_rd_req && !pend) begin
        pend = 1; cnt = lat;
        if (rd_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected read actual=%h expected=none", mem_rd_addr);
        end else chk("R3", "read address", mem_rd_addr, rd_q.pop_front());
      end
      if (pend) begin
        if (cnt == 0) begin
          mem_rd_valid = 1; mem_rd_data = rdm(mem_rd_addr); pend = 0;
        end else cnt--;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12 extra done actual=1 expected=0");
        end else begin
          e = exp_q.pop_front();
          chk(e.tag, "paddr", res_paddr, e.pa);
          chk(e.tag, "super", {31'b0, res_super}, {31'b0, e.sup});
          chk("R8", "prot", {29'b0, res_prot}, {29'b0, e.prot});
          chk(e.tag, "fault", {27'b0, res_fault}, {27'b0, e.code});
          chk("R11", "itrap", {31'b0, itrap}, {31'b0, e.it});
          chk("R11", "dtrap", {31'b0, dtrap}, {31'b0, e.dt});
          chk("R10", "flt_status", {27'b0, flt_status}, {27'b0, e.fs});
          chk("R10", "flt_addr", flt_addr, e.fa);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] VA_T = 32'h8180_0000;

  initial begin
    tbl[BASE + 32'h204*4] = 32'hC000_01C7;
    tbl[BASE + 32'h205*4] = 32'hC000_01C3;
    tbl[BASE + 32'h206*4] = 32'h0020_0004;
    tbl[BASE + 32'h207*4] = 32'h0030_0000;
    tbl[BASE + 32'h208*4] = 32'h0000_0005;
    tbl[BASE + 32'h209*4] = 32'h0000_0006;
    tbl[BASE + 32'h001*4] = 32'h0040_0004;
    tbl[32'h0020_0000 + 0*4] = 32'h1234_51C4;
    tbl[32'h0020_0000 + 1*4] = 32'h0000_0003;
    tbl[32'h0020_0000 + 2*4] = 32'h5555_5006;
    tbl[32'h0020_0000 + 3*4] = 32'h7777_7004;
    tbl[32'h0020_0000 + 4*4] = 32'h6666_6104;
    tbl[32'h0040_0000 + 5*4] = 32'h0ABC_D1C4;

    repeat (3) @(negedge clk);
    // R10 R12: reset state
    chk("R12", "done at reset", {31'b0, done}, 32'h0);
    chk("R12", "busy at reset", {31'b0, busy}, 32'h0);
    chk("R10", "flt_status at reset", {27'b0, flt_status}, 32'h0);
    chk("R10", "flt_addr at reset", flt_addr, 32'h0);
    chk("R3", "mem_rd_req at reset", {31'b0, mem_rd_req}, 32'h0);
    rst_n = 1;

    run("R1", 32'h1234_5678, 2'd0, 1'b1, 1'b0);
    run("R1", 32'h8765_4321, 2'd2, 1'b0, 1'b0);
    run("R2", 32'h0000_4ABC, 2'd1, 1'b0, 1'b1);
    lat = 0;
    run("R4", 32'h8123_4567, 2'd0, 1'b1, 1'b1);
    lat = 2;
    run("R4", 32'h8143_0000, 2'd1, 1'b1, 1'b1);
    run("R6", VA_T | 32'h0000_0ABC, 2'd1, 1'b1, 1'b1);
    lat = 1;
    run("R5", 32'h81C0_0010, 2'd0, 1'b0, 1'b1);
    run("R6", VA_T | 32'h0000_1000, 2'd0, 1'b1, 1'b1);
    run("R7", 32'h8200_0000, 2'd0, 1'b1, 1'b1);
    run("R7", 32'h8240_0000, 2'd2, 1'b0, 1'b1);
    run("R7", VA_T | 32'h0000_2004, 2'd0, 1'b0, 1'b1);
    lat = 3;
    run("R9", VA_T | 32'h0000_3010, 2'd0, 1'b1, 1'b1);
    run("R9", VA_T | 32'h0000_3020, 2'd1, 1'b1, 1'b1);
    run("R9", VA_T | 32'h0000_3030, 2'd2, 1'b1, 1'b1);
    run("R9", VA_T | 32'h0000_3040, 2'd3, 1'b1, 1'b1);
    run("R9", VA_T | 32'h0000_3050, 2'd2, 1'b0, 1'b1);
    run("R9", VA_T | 32'h0000_4060, 2'd0, 1'b1, 1'b1);
    run("R9", VA_T | 32'h0000_4070, 2'd1, 1'b1, 1'b1);
    lat = 0;
    run("R10", 32'h0045_5123, 2'd2, 1'b1, 1'b1);
    run("R12", VA_T | 32'h0000_0008, 2'd0, 1'b1, 1'b1, 1);
    lat = 2;
    run("R12", 32'h8123_0000, 2'd2, 1'b1, 1'b1, 1);

    repeat (5) @(negedge clk);
    chk("R12", "pending results", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule